// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C bus target that behaves like a small byte-addressed serial EEPROM. The array is built from on-chip registers. The block watches the SCL and SDA lines through synchronizing flip-flops. It finds START, repeated START and STOP conditions and decodes the device-address byte. It acknowledges bytes by pulling SDA low through an output-enable, which an open-drain pad turns into a wired-AND line.

A write transfer carries the device address and then one word-address byte. That byte sets the low eight bits of the current address. Every byte after it is stored at the current address, which then advances. A read transfer returns bytes from the current address, most significant bit first, and the address advances after each byte.

The device address has low bits that are not compared. When the array is larger than 256 bytes, those bits become the high bits of the memory address. One block therefore answers several consecutive bus addresses. The address wraps across the whole array, not within a page.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, sda_oe is 0, the current address is 0 and every array byte reads 0xFF.
- R2: A device-address byte is acknowledged only when its bits [7:1] equal DEV_BASE, ignoring the low log2(MEM_BYTES/256) bits (with the defaults, 0x50 to 0x53 match). Bit 0 of the byte is 1 for a read and 0 for a write. After an address that does not match, no byte is acknowledged until the next START.
- R3: On a matching address, current-address bits [AW-1:8] are replaced by the ignored low bits of the device address.
- R4: In a write transfer, the first byte after the address replaces the low 8 bits of the current address and is acknowledged.
- R5: Each later byte of a write transfer is stored at the current address and acknowledged. The address then increments modulo MEM_BYTES.
- R6: In a read transfer, each byte is sent MSB first from the current address. The address then increments modulo MEM_BYTES. The address is kept across STOP and START.
- R7: A master ACK after a read byte makes the block send the next byte. After a master NACK the block releases SDA and stays in the read state. A byte the master then clocks in is answered with NACK, is not stored and leaves the address unchanged.
- R8: A repeated START decodes a new device-address byte at once, so a write of the word address can be followed by a read without a STOP.
- R9: A STOP releases SDA and returns the control state to stopped.
- R10: The block only ever pulls SDA low, during ACK bits and zero data bits. It starts to pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The bench drives writes that cross the top of the array, to check that the address wraps to 0 and not within a page. A design that wrapped per page would read back the wrong bytes. It reaches the same word address through different device addresses, so a design that ignored the high address bits would return data from the wrong bank. After a master NACK it clocks in one more byte. A design that stored this byte, or moved the address, would show the wrong data on the next read. Finally it checks that the address stays the same across STOP and START, and that the neighbouring device addresses get no acknowledge.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    // control sequencing of a transfer
    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_ADDR  = 2'd1,
        CT_READ  = 2'd2,
        CT_WRITE = 2'd3
    } ctl_e;

    // bit-level phase of the byte engine
    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_RECV   = 3'd1,
        PH_ACKOUT = 3'd2,
        PH_SEND   = 3'd3,
        PH_ACKIN  = 3'd4
    } phase_e;
endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl_a;
        logic scl_b;
        logic scl_c;
        logic sda_a;
        logic sda_b;
        logic sda_c;
    } line_t;

    line_t ln_d, ln_q;

    always_comb begin
        ln_d       = ln_q;
        ln_d.scl_a = scl_i;
        ln_d.scl_b = ln_q.scl_a;
        ln_d.scl_c = ln_q.scl_b;
        ln_d.sda_a = sda_i;
        ln_d.sda_b = ln_q.sda_a;
        ln_d.sda_c = ln_q.sda_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '1;
        else        ln_q <= ln_d;
    end

    assign scl_hi    = ln_q.scl_b;
    assign sda_lvl   = ln_q.sda_b;
    assign scl_rise  = ln_q.scl_b & ~ln_q.scl_c;
    assign scl_fall  = ~ln_q.scl_b & ln_q.scl_c;
    assign start_det = ln_q.scl_b & ln_q.scl_c & ~ln_q.sda_b & ln_q.sda_c;
    assign stop_det  = ln_q.scl_b & ln_q.scl_c & ln_q.sda_b & ~ln_q.sda_c;
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cell_q [DEPTH];

    // erased array reads all ones after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int         MEM_BYTES = 1024,
    parameter logic [6:0] DEV_BASE  = 7'h50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int         AW       = $clog2(MEM_BYTES);
    localparam int         HIB      = (AW > 8) ? (AW - 8) : 0;
    localparam logic [6:0] DEV_MASK = 7'((1 << HIB) - 1);

    typedef struct packed {
        ctl_e          ctl;
        phase_e        ph;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [AW-1:0] addr;
        logic          is_dev;
        logic          go_tx;
        logic          mack;
        logic          oe;
    } eng_t;

    eng_t eng_d, eng_q;

    logic scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          mem_we;
    logic [7:0]    rdata;
    logic [AW-1:0] addr_after_dev, addr_after_low, addr_inc;
    logic          dev_match;

    i2c_line_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_hi   (scl_hi),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_ee_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(eng_q.addr),
        .wdata(eng_q.sh),
        .raddr(eng_q.addr),
        .rdata(rdata)
    );

    // parameter picks how device-address bits fold into the word address
    generate
        if (AW > 8) begin : g_banked
            assign addr_after_dev = {eng_q.sh[HIB:1], eng_q.addr[7:0]};
            assign addr_after_low = {eng_q.addr[AW-1:8], eng_q.sh};
        end else begin : g_flat
            assign addr_after_dev = eng_q.addr;
            assign addr_after_low = eng_q.sh[AW-1:0];
        end
    endgenerate

    assign addr_inc  = eng_q.addr + {{(AW-1){1'b0}}, 1'b1};
    assign dev_match = ((eng_q.sh[7:1] ^ DEV_BASE) & ~DEV_MASK) == 7'd0;

    always_comb begin
        eng_d  = eng_q;
        mem_we = 1'b0;
        if (stop_det) begin
            eng_d.ph  = PH_OFF;
            eng_d.ctl = CT_IDLE;
            eng_d.oe  = 1'b0;
        end else if (start_det) begin
            eng_d.ph     = PH_RECV;
            eng_d.cnt    = 4'd0;
            eng_d.is_dev = 1'b1;
            eng_d.go_tx  = 1'b0;
            eng_d.oe     = 1'b0;
        end else begin
            case (eng_q.ph)
                PH_RECV: begin
                    if (scl_rise) begin
                        eng_d.sh  = {eng_q.sh[6:0], sda_lvl};
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall && eng_q.cnt == 4'd8) begin
                        eng_d.ph    = PH_ACKOUT;
                        eng_d.go_tx = 1'b0;
                        if (eng_q.is_dev) begin
                            if (dev_match) begin
                                eng_d.oe    = 1'b1;
                                eng_d.addr  = addr_after_dev;
                                eng_d.ctl   = eng_q.sh[0] ? CT_READ : CT_ADDR;
                                eng_d.go_tx = eng_q.sh[0];
                            end else begin
                                eng_d.ph  = PH_OFF;
                                eng_d.ctl = CT_IDLE;
                                eng_d.oe  = 1'b0;
                            end
                        end else if (eng_q.ctl == CT_ADDR) begin
                            eng_d.addr = addr_after_low;
                            eng_d.ctl  = CT_WRITE;
                            eng_d.oe   = 1'b1;
                        end else if (eng_q.ctl == CT_WRITE) begin
                            mem_we     = 1'b1;
                            eng_d.addr = addr_inc;
                            eng_d.oe   = 1'b1;
                        end else begin
                            eng_d.oe = 1'b0;
                        end
                    end
                end
                PH_ACKOUT: begin
                    if (scl_fall) begin
                        if (eng_q.go_tx) begin
                            eng_d.sh   = rdata;
                            eng_d.addr = addr_inc;
                            eng_d.ph   = PH_SEND;
                            eng_d.cnt  = 4'd0;
                            eng_d.oe   = ~rdata[7];
                        end else begin
                            eng_d.ph     = PH_RECV;
                            eng_d.cnt    = 4'd0;
                            eng_d.is_dev = 1'b0;
                            eng_d.oe     = 1'b0;
                        end
                    end
                end
                PH_SEND: begin
                    if (scl_fall) begin
                        if (eng_q.cnt == 4'd7) begin
                            eng_d.ph = PH_ACKIN;
                            eng_d.oe = 1'b0;
                        end else begin
                            eng_d.sh  = {eng_q.sh[6:0], 1'b0};
                            eng_d.cnt = eng_q.cnt + 4'd1;
                            eng_d.oe  = ~eng_q.sh[6];
                        end
                    end
                end
                PH_ACKIN: begin
                    if (scl_rise) begin
                        eng_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (eng_q.mack) begin
                            eng_d.sh   = rdata;
                            eng_d.addr = addr_inc;
                            eng_d.ph   = PH_SEND;
                            eng_d.cnt  = 4'd0;
                            eng_d.oe   = ~rdata[7];
                        end else begin
                            eng_d.ph     = PH_RECV;
                            eng_d.cnt    = 4'd0;
                            eng_d.is_dev = 1'b0;
                            eng_d.go_tx  = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.ctl  <= CT_IDLE;
            eng_q.ph   <= PH_OFF;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe = eng_q.oe;

    // R10
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.oe) |-> !scl_hi);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!eng_q.oe && eng_q.ctl == CT_IDLE && eng_q.ph == PH_OFF));

    // R5
    write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (eng_q.addr == AW'($past(eng_q.addr) + 1'b1)));

    // R7
    refuse_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.ph == PH_ACKOUT && eng_q.ctl == CT_READ && !eng_q.go_tx) |-> !eng_q.oe);

    // R8
    restart_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (eng_q.ph == PH_RECV && eng_q.is_dev && eng_q.cnt == 4'd0));
endmodule

// File: tb/tb_i2c_eeprom_target.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_target;
    localparam int         MEM  = 1024;
    localparam logic [6:0] BASE = 7'h50;
    localparam int         Q    = 10;
    localparam int         HIB  = $clog2(MEM) - 8;
    localparam int         LOWM = (1 << HIB) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_eeprom_target #(.MEM_BYTES(MEM), .DEV_BASE(BASE)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_m),
        .sda_i (sda_bus),
        .sda_oe(sda_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    int ref_mem [MEM];
    int ref_addr = 0;
    int ref_st = 0;      // 0 stopped, 1 addressing, 2 reading, 3 writing
    bit ref_mute = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_clock(output bit s);
        qw(Q);
        scl_m = 1'b1;
        qw(Q / 2);
        s = sda_bus;
        qw(Q / 2);
        scl_m = 1'b0;
        qw(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(Q);
        scl_m = 1'b1; qw(Q);
        sda_m = 1'b0; qw(Q);
        scl_m = 1'b0; qw(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(Q);
        scl_m = 1'b1; qw(Q);
        sda_m = 1'b1; qw(Q);
        ref_st = 0;
        ref_mute = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            bit_clock(s);
        end
        sda_m = 1'b1;
        bit_clock(s);
        acked = !s;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        bit s;
        sda_m = 1'b1;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bit_clock(s);
            d = {d[6:0], s};
        end
        sda_m = !mack;
        bit_clock(s);
        sda_m = 1'b1;
    endtask

    // START (or repeated START) plus device address byte, checked against model
    task automatic dev(input logic [6:0] d7, input bit rw, input string req);
        bit a, exp;
        exp = (((int'(d7) ^ int'(BASE)) & ~LOWM & 8'h7F) == 0);
        bus_start();
        write_byte({d7, rw}, a);
        chk(a == exp, req, a, exp);
        if (exp) begin
            ref_addr = (ref_addr & 8'hFF) | ((int'(d7) & LOWM) << 8);
            ref_st = rw ? 2 : 1;
            ref_mute = 1'b0;
        end else begin
            ref_st = 0;
            ref_mute = 1'b1;
        end
    endtask

    task automatic wr(input logic [7:0] b, input string req);
        bit a, exp;
        exp = 1'b0;
        if (!ref_mute) begin
            if (ref_st == 1) begin
                ref_addr = (ref_addr & ~8'hFF) | int'(b);
                ref_st = 3;
                exp = 1'b1;
            end else if (ref_st == 3) begin
                ref_mem[ref_addr] = int'(b);
                ref_addr = (ref_addr + 1) % MEM;
                exp = 1'b1;
            end
        end
        write_byte(b, a);
        chk(a == exp, req, a, exp);
    endtask

    task automatic rd(input bit mack, input string req);
        logic [7:0] d;
        int exp;
        exp = ref_mem[ref_addr];
        ref_addr = (ref_addr + 1) % MEM;
        read_byte(mack, d);
        chk(int'(d) == exp, req, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM; i++) ref_mem[i] = 8'hFF;
        qw(5);
        rst_n = 1'b1;
        qw(5);
        // R1: line released after reset
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);

        // R1 R6: current-address read at 0 returns erased value
        dev(7'h50, 1'b1, "R2");
        rd(1'b0, "R1");
        bus_stop();
        // R9: released after STOP
        chk(sda_oe == 1'b0, "R9", sda_oe, 0);

        // R2: neighbours outside the range are ignored, even for data bytes
        dev(7'h54, 1'b0, "R2");
        wr(8'h12, "R2");
        bus_stop();
        dev(7'h4F, 1'b0, "R2");
        bus_stop();

        // R4 R5: word address then a burst
        dev(7'h50, 1'b0, "R2");
        wr(8'h10, "R4");
        wr(8'hA5, "R5");
        wr(8'h3C, "R5");
        wr(8'h00, "R5");
        bus_stop();

        // R8 R6 R7: random read with repeated START
        dev(7'h50, 1'b0, "R2");
        wr(8'h10, "R4");
        dev(7'h50, 1'b1, "R8");
        rd(1'b1, "R6");
        rd(1'b1, "R7");
        rd(1'b0, "R6");
        bus_stop();

        // R3: upper bank through device address 0x52
        dev(7'h52, 1'b0, "R3");
        wr(8'h34, "R4");
        wr(8'h77, "R3");
        wr(8'h88, "R3");
        bus_stop();
        dev(7'h52, 1'b0, "R3");
        wr(8'h34, "R4");
        dev(7'h52, 1'b1, "R3");
        rd(1'b1, "R3");
        rd(1'b0, "R3");
        bus_stop();
        dev(7'h50, 1'b0, "R3");
        wr(8'h34, "R4");
        dev(7'h50, 1'b1, "R3");
        rd(1'b0, "R3");
        bus_stop();

        // R5 R6: wrap at the top of the whole array
        dev(7'h53, 1'b0, "R5");
        wr(8'hFF, "R4");
        wr(8'hE1, "R5");
        wr(8'hE2, "R5");
        bus_stop();
        dev(7'h53, 1'b0, "R6");
        wr(8'hFF, "R4");
        dev(7'h53, 1'b1, "R6");
        rd(1'b1, "R6");
        rd(1'b0, "R6");
        bus_stop();

        // R7: byte clocked in after master NACK is refused and not stored
        dev(7'h50, 1'b0, "R7");
        wr(8'h10, "R4");
        dev(7'h50, 1'b1, "R7");
        rd(1'b0, "R7");
        wr(8'h5A, "R7");
        dev(7'h50, 1'b1, "R7");
        rd(1'b0, "R7");
        bus_stop();

        // R6 R9: address survives STOP/START
        dev(7'h50, 1'b1, "R9");
        rd(1'b0, "R9");
        bus_stop();
        chk(sda_oe == 1'b0, "R10", sda_oe, 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule